// File: doc/BRIEF.md
# Manchester Frame Serializer

This block turns one sensor sample into a serial frame on a single modulation-enable line. The line is high while extra bus current should be drawn and low while the bus sits at idle current. When the block is idle and sees a start strobe, it captures the sample and its settings, then sends the frame. The settings are the payload width (8 or 10 bits), the trailer kind (a 3-bit CRC or one even-parity bit) and the coding phase.

Each frame has two start bits, then the payload with the MSB first, then the trailer. Every bit takes one cell of eight timebase clocks. The bit value is carried by the direction of the edge in the middle of the cell. The coding phase selects which edge direction means which value, and it also selects the start-bit pattern. After the last bit, the line stays low for one more cell before the busy flag drops. The logic that chooses when to send a frame, and the analog current stage, sit outside this block.

Top module: `manchester_frame_tx`

## Requirements
- R1: After reset, and in every cycle where `busy_o` is low, `mod_o` is 0 and no frame is in progress.
- R2: Every frame bit takes one cell of 8 clocks. `mod_o` holds one level for the first 4 clocks of the cell and the opposite level for the last 4 clocks, so each cell has exactly one mid-cell edge.
- R3: With `phase_i`=0 the start bits are 1 then 0. A 1 is sent as low then high (rising mid-cell edge) and a 0 as high then low (falling mid-cell edge).
- R4: With `phase_i`=1 the start bits are 0 then 0. A 0 is sent as low then high (rising edge) and a 1 as high then low (falling edge).
- R5: With `wide_i`=1 the payload is `data_i[9:0]`. With `wide_i`=0 it is `data_i[7:0]`, and `data_i[9:8]` have no effect. The payload is sent MSB first, straight after the start bits.
- R6: With `crc_sel_i`=1 the trailer is a 3-bit CRC with generator x^3+x+1. The register starts at 000 and takes only the payload bits, MSB first. For each bit b: f = r[2]^b, and r becomes {r[1], r[0]^f, f}. r[2] is sent first.
- R7: With `crc_sel_i`=0 the trailer is one bit, equal to the XOR of all payload bits, so the payload plus this bit holds an even number of ones.
- R8: After the last frame bit, `mod_o` stays 0 for 8 more clocks while `busy_o` stays high. `busy_o` is therefore high for exactly (2 + payload bits + trailer bits) × 8 + 8 clocks.
- R9: A start strobe while `busy_o` is high is ignored. Changes to `data_i`, `wide_i`, `crc_sel_i` and `phase_i` during a frame do not change that frame.
- R10: A strobe sampled while idle raises `busy_o` at the next clock edge. The first half of the first start bit appears on `mod_o` at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request strobe, sampled while idle |
| data_i | input | 10 | Sensor sample; only bits 7:0 are used in 8-bit mode |
| wide_i | input | 1 | 1 = 10-bit payload, 0 = 8-bit payload |
| crc_sel_i | input | 1 | 1 = 3-bit CRC trailer, 0 = even-parity bit |
| phase_i | input | 1 | 0 = default coding phase, 1 = alternate phase |
| busy_o | output | 1 | High from frame start to the end of the trailing idle cell |
| mod_o | output | 1 | Modulation enable (high = draw extra current) |

## Verification
The bound checker checks the following on every cycle: `mod_o` is low whenever the block is idle, and the level is constant inside each half cell. It also checks that every frame cell has a mid-cell edge, that the trailing cell stays low, and that `busy_o` lasts exactly the length fixed at the accepted strobe, which a restart would break. The checker cannot see which bit values are sent. Those come only from the bench's scenarios, which compare every sample against an independently built waveform. The scenarios cover both phases, both widths, both trailer kinds, ignored upper data bits, and a strobe with changed settings in the middle of a frame.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

    localparam int DATA_MAX  = 10;
    localparam int DATA_MIN  = 8;
    localparam int CRC_W     = 3;
    localparam int PAR_W     = 1;
    localparam int START_W   = 2;
    localparam int CELL_CLKS = 8;
    localparam int FRAME_MAX = START_W + DATA_MAX + CRC_W;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEND = 2'd1,
        SQ_TAIL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;   // left-justified, MSB goes out first
        logic [LEN_W-1:0]     len;    // number of valid bits
        logic                 phase;  // coding phase for this frame
    } frame_t;

    // CRC x^3 + x + 1, zero seed, payload bits only, MSB first
    function automatic logic [CRC_W-1:0] crc3_payload(
        input logic [DATA_MAX-1:0] d,
        input logic                wide
    );
        logic [CRC_W-1:0] r;
        logic             f;
        r = '0;
        for (int i = DATA_MAX - 1; i >= 0; i--) begin
            if (wide || i < DATA_MIN) begin
                f = r[2] ^ d[i];
                r = {r[1], r[0] ^ f, f};
            end
        end
        return r;
    endfunction

    function automatic logic even_parity(
        input logic [DATA_MAX-1:0] d,
        input logic                wide
    );
        return wide ? ^d : ^d[DATA_MIN-1:0];
    endfunction

    // Line level for a bit in a given half cell; phase 0: 1 = low->high
    function automatic logic line_level(
        input logic bit_val,
        input logic phase,
        input logic second_half
    );
        return bit_val ^ phase ^ ~second_half;
    endfunction

endpackage

// File: rtl/mfs_frame_build.sv
module mfs_frame_build
    import mfs_pkg::*;
(
    input  logic [DATA_MAX-1:0] data_i,
    input  logic                wide_i,
    input  logic                crc_sel_i,
    input  logic                phase_i,
    output frame_t              frame_o
);
    localparam int PW_W = $clog2(DATA_MAX + 1);

    logic [START_W-1:0]   start_bits;
    logic [DATA_MAX-1:0]  pay_just;
    logic [CRC_W-1:0]     chk_just;
    logic [PW_W-1:0]      pay_w;
    logic [LEN_W-1:0]     chk_w;
    logic [FRAME_MAX-1:0] head;
    logic [FRAME_MAX-1:0] tail;
    logic [LEN_W-1:0]     tail_shift;

    always_comb begin
        start_bits = {~phase_i, 1'b0};
        pay_w      = wide_i ? PW_W'(DATA_MAX) : PW_W'(DATA_MIN);
        pay_just   = wide_i ? data_i
                            : {data_i[DATA_MIN-1:0], {(DATA_MAX-DATA_MIN){1'b0}}};
        if (crc_sel_i) begin
            chk_just = crc3_payload(data_i, wide_i);
            chk_w    = LEN_W'(CRC_W);
        end else begin
            chk_just = {even_parity(data_i, wide_i), {(CRC_W-PAR_W){1'b0}}};
            chk_w    = LEN_W'(PAR_W);
        end
        tail_shift    = LEN_W'(START_W) + LEN_W'(pay_w);
        head          = {start_bits, pay_just, {CRC_W{1'b0}}};
        tail          = {chk_just, {(FRAME_MAX-CRC_W){1'b0}}} >> tail_shift;
        frame_o.bits  = head | tail;
        frame_o.len   = tail_shift + chk_w;
        frame_o.phase = phase_i;
    end
endmodule

// File: rtl/mfs_sequencer.sv
module mfs_sequencer
    import mfs_pkg::*;
#(
    parameter int CELL = CELL_CLKS
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  frame_t frame_i,
    output logic   busy_o,
    output logic   sending_o,
    output logic   cur_bit_o,
    output logic   second_half_o,
    output logic   phase_o
);
    localparam int CNT_W = (CELL > 1) ? $clog2(CELL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CELL - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CELL / 2);

    seq_state_e           state;
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     bits_left;
    logic [CNT_W-1:0]     cell_cnt;
    logic                 phase_q;
    logic                 cell_end;

    assign cell_end = (cell_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            shreg     <= '0;
            bits_left <= '0;
            cell_cnt  <= '0;
            phase_q   <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_i) begin
                        state     <= SQ_SEND;
                        shreg     <= frame_i.bits;
                        bits_left <= frame_i.len;
                        phase_q   <= frame_i.phase;
                        cell_cnt  <= '0;
                    end
                end
                SQ_SEND: begin
                    if (cell_end) begin
                        cell_cnt  <= '0;
                        shreg     <= {shreg[FRAME_MAX-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == LEN_W'(1)) state <= SQ_TAIL;
                    end else begin
                        cell_cnt <= cell_cnt + 1'b1;
                    end
                end
                SQ_TAIL: begin
                    if (cell_end) begin
                        cell_cnt <= '0;
                        state    <= SQ_IDLE;
                    end else begin
                        cell_cnt <= cell_cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o        = (state != SQ_IDLE);
    assign sending_o     = (state == SQ_SEND);
    assign cur_bit_o     = shreg[FRAME_MAX-1];
    assign second_half_o = (cell_cnt >= CNT_HALF);
    assign phase_o       = phase_q;
endmodule

// File: rtl/mfs_line_encoder.sv
module mfs_line_encoder
    import mfs_pkg::*;
(
    input  logic sending_i,
    input  logic bit_i,
    input  logic phase_i,
    input  logic second_half_i,
    output logic mod_o
);
    always_comb begin
        mod_o = sending_i & line_level(bit_i, phase_i, second_half_i);
    end
endmodule

// File: rtl/manchester_frame_tx.sv
module manchester_frame_tx
    import mfs_pkg::*;
#(
    parameter int CELL = CELL_CLKS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [DATA_MAX-1:0] data_i,
    input  logic                wide_i,
    input  logic                crc_sel_i,
    input  logic                phase_i,
    output logic                busy_o,
    output logic                mod_o
);
    frame_t frame;
    logic   sending;
    logic   cur_bit;
    logic   second_half;
    logic   phase_act;

    mfs_frame_build u_build (
        .data_i    (data_i),
        .wide_i    (wide_i),
        .crc_sel_i (crc_sel_i),
        .phase_i   (phase_i),
        .frame_o   (frame)
    );

    mfs_sequencer #(.CELL(CELL)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .frame_i       (frame),
        .busy_o        (busy_o),
        .sending_o     (sending),
        .cur_bit_o     (cur_bit),
        .second_half_o (second_half),
        .phase_o       (phase_act)
    );

    mfs_line_encoder u_enc (
        .sending_i     (sending),
        .bit_i         (cur_bit),
        .phase_i       (phase_act),
        .second_half_i (second_half),
        .mod_o         (mod_o)
    );
endmodule

// File: rtl/mfs_checker.sv
module mfs_checker
    import mfs_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic wide_i,
    input logic crc_sel_i,
    input logic busy_o,
    input logic mod_o
);
    localparam int TOT_MAX = (FRAME_MAX + 1) * CELL_CLKS;
    localparam int TW      = $clog2(TOT_MAX + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] frame_cyc;
    logic [TW-1:0] total_cyc;
    logic [TW-1:0] pos;
    logic          accept;

    assign accept = start_i && !busy_o;
    assign pos    = cnt % TW'(CELL_CLKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            frame_cyc <= '0;
            total_cyc <= '0;
        end else if (accept) begin
            cnt       <= '0;
            frame_cyc <= TW'((START_W + (wide_i ? DATA_MAX : DATA_MIN)
                              + (crc_sel_i ? CRC_W : PAR_W)) * CELL_CLKS);
            total_cyc <= TW'((START_W + (wide_i ? DATA_MAX : DATA_MIN)
                              + (crc_sel_i ? CRC_W : PAR_W) + 1) * CELL_CLKS);
        end else if (busy_o) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mod_o);

    a_r2_half_stable: assert property (@(posedge clk) disable iff (rst)
        busy_o && cnt != '0 && pos != '0 && pos != TW'(CELL_CLKS / 2)
        |-> $stable(mod_o));

    a_r2_mid_edge: assert property (@(posedge clk) disable iff (rst)
        busy_o && cnt < frame_cyc && pos == TW'(CELL_CLKS / 2)
        |-> mod_o != $past(mod_o));

    a_r8_tail_low: assert property (@(posedge clk) disable iff (rst)
        busy_o && cnt >= frame_cyc |-> !mod_o);

    a_r8_busy_ends: assert property (@(posedge clk) disable iff (rst)
        busy_o && cnt == total_cyc - 1'b1 |=> !busy_o);

    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy_o && cnt < total_cyc - 1'b1 |=> busy_o);

    a_r10_busy_rise: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o);
endmodule

bind manchester_frame_tx mfs_checker u_mfs_checker (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .wide_i    (wide_i),
    .crc_sel_i (crc_sel_i),
    .busy_o    (busy_o),
    .mod_o     (mod_o)
);

// File: tb/test_manchester_frame_tx.sv
module test_manchester_frame_tx;
    localparam time CLK_PERIOD = 1000ns;
    localparam int  CELL       = 8;

    typedef struct {
        logic  lvl;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [9:0] data_i = '0;
    logic       wide_i = 1'b0;
    logic       crc_sel_i = 1'b0;
    logic       phase_i = 1'b0;
    logic       busy_o;
    logic       mod_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    manchester_frame_tx i_manchester_frame_tx (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .data_i    (data_i),
        .wide_i    (wide_i),
        .crc_sel_i (crc_sel_i),
        .phase_i   (phase_i),
        .busy_o    (busy_o),
        .mod_o     (mod_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // monitor: pop expected level per busy cycle; idle must be low
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected busy cycle", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mod_o == e.lvl, e.tag, int'(mod_o), int'(e.lvl));
                end
            end else begin
                check(mod_o == 1'b0, "R1 idle line low", int'(mod_o), 0);
            end
        end
    end

    task automatic push_bit(input logic b, input logic ph, input string tag);
        logic first;
        first = ph ? b : ~b;
        for (int k = 0; k < CELL; k++)
            exp_q.push_back('{lvl: (k < CELL / 2) ? first : ~first, tag: tag});
    endtask

    // driver: builds expected waveform, strobes, optionally disturbs mid-frame
    task automatic send(input logic [9:0] d, input logic w, input logic c,
                        input logic ph, input bit poke, input string tag);
        int   nb;
        int   len;
        int   cyc;
        logic [2:0] r;
        logic f;
        logic par;
        nb  = w ? 10 : 8;
        len = 2 + nb + (c ? 3 : 1);
        push_bit(ph ? 1'b0 : 1'b1, ph, {tag, " R3/R4 start bit1"});
        push_bit(1'b0, ph, {tag, " R3/R4 start bit2"});
        r = 3'b000;
        par = 1'b0;
        for (int i = nb - 1; i >= 0; i--) begin
            push_bit(d[i], ph, {tag, " R5 payload"});
            f = r[2] ^ d[i];
            r = {r[1], r[0] ^ f, f};
            par = par ^ d[i];
        end
        if (c) begin
            for (int i = 2; i >= 0; i--) push_bit(r[i], ph, {tag, " R6 crc"});
        end else begin
            push_bit(par, ph, {tag, " R7 parity"});
        end
        for (int k = 0; k < CELL; k++) exp_q.push_back('{lvl: 1'b0, tag: {tag, " R8 tail"}});

        data_i = d; wide_i = w; crc_sel_i = c; phase_i = ph;
        check(busy_o == 1'b0, "R10 idle before strobe", int'(busy_o), 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10 busy after strobe", int'(busy_o), 1);
        cyc = 0;
        while (busy_o) begin
            cyc++;
            if (poke && cyc == 20) begin
                start_i = 1'b1; data_i = ~d; wide_i = ~w; crc_sel_i = ~c; phase_i = ~ph;
            end
            if (poke && cyc == 21) start_i = 1'b0;
            @(negedge clk);
        end
        check(cyc == len * CELL + CELL, {tag, " R8/R9 busy length"}, cyc, len * CELL + CELL);
        check(exp_q.size() == 0, {tag, " R8 frame complete"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        check(mod_o == 1'b0, "R1 reset line", int'(mod_o), 0);

        send(10'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, "f1 R3 R7 default 8b");
        send(10'h3C9, 1'b1, 1'b1, 1'b0, 1'b0, "f2 R3 R6 default 10b");
        send(10'h000, 1'b0, 1'b1, 1'b1, 1'b0, "f3 R4 R6 alt 8b zero");
        send(10'h3FF, 1'b1, 1'b0, 1'b1, 1'b0, "f4 R4 R7 alt 10b ones");
        send(10'h35A, 1'b0, 1'b1, 1'b0, 1'b0, "f5 R5 upper bits ignored");
        send(10'h16B, 1'b1, 1'b1, 1'b1, 1'b1, "f6 R9 strobe mid-frame");
        send(10'h081, 1'b0, 1'b0, 1'b1, 1'b1, "f7 R9 R2 settings change");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule